// File: doc/BRIEF.md
# Interleaved Double-Half SECDED Word Protector

This block sits between a 128-bit wide memory array and the logic that reads and writes it. On the write side it takes a 128-bit data word, codes each 64-bit half on its own with an extended Hamming code, and returns a 144-bit word to store. An error mask of the same width is XORed into that word, so test software or a bench can plant faults in chosen physical bits. On the read side it takes a 144-bit stored word, splits it back into the two coded halves, repairs any single-bit fault in each half, and flags any half that holds two faults.

The two halves are spread over the stored word in alternating bit positions, and so are their check bytes. A burst that hits two neighbouring physical cells therefore lands as one fault in each half, and both faults are corrected. The data correction is combinational. The per-half status flags, a status strobe and one-cycle error events are registered, and they appear in the clock cycle after a read word is presented.

Top module: `pairEccGuard`

## Requirements
- R1: In the stored word, bit i (0..63) of data half h (half 0 = data[63:0], half 1 = data[127:64]) sits at physical bit 2i+h, and check bit j (0..7) of half h sits at physical bit 128+2j+h.
- R2: Within a half, data bit i takes the i-th Hamming position, counted from 0 and starting at 3, that is not a power of two. Check bit k (0..6) is the XOR of the data bits whose position has bit k set. Check bit 7 gives the 72-bit codeword of that half even parity.
- R3: The stored word equals the encoded word XOR the injection mask, bit for bit.
- R4: A read of a fault-free stored word returns the written data and raises no correctable or uncorrectable flag.
- R5: A single flipped bit in a half returns that half's original data and raises that half's correctable flag. This holds when the bit is a data bit, a Hamming check bit or the overall parity bit.
- R6: Two flipped bits in one half raise that half's uncorrectable flag, clear its correctable flag, and return that half's data as read, without correction.
- R7: The halves are decoded independently. Faults in two adjacent physical bits are each corrected, and both correctable flags are set.
- R8: The status strobe is high in exactly the cycle after a cycle with the read-valid input high. The per-half flags registered with it describe that read.
- R9: While read-valid is low, the registered per-half flags keep their values.
- R10: The correctable event pulses high for one cycle after a read in which any half was correctable. The uncorrectable event does the same for reads with any uncorrectable half. Both events are low otherwise.
- R11: While reset is asserted and after it is released, the strobe, the flags and the events are all low until the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 128 | Data to be written |
| wrInject | input | 144 | Per-bit fault mask XORed into the stored word |
| wrWord | output | 144 | Interleaved coded word to store |
| rdValid | input | 1 | rdWord is a real read in this cycle |
| rdWord | input | 144 | Stored word read from the array |
| rdData | output | 128 | Corrected read data (combinational) |
| stValid | output | 1 | Registered status strobe |
| stCorr | output | 2 | Per-half correctable flag, bit h for half h |
| stUncorr | output | 2 | Per-half uncorrectable flag |
| evCorr | output | 1 | Correctable error event pulse |
| evUncorr | output | 1 | Uncorrectable error event pulse |

## Verification
The assertions check the timing of the status path on every cycle. They cover the strobe following read-valid by one cycle, the flags holding while no read occurs, a half never being both correctable and uncorrectable, events only appearing with a strobe and a matching flag, and a clean loop-back of the write word raising no flag. The bench scenarios are needed for the code itself. They cover the exact physical layout and check values, correction of every single-bit fault position in both halves, detection of double faults with unrepaired data, and the split of neighbouring-bit bursts across the halves. A behavioural model in the bench predicts these results.

// File: rtl/pairEccPkg.sv
package pairEccPkg;
  parameter int HALF_W = 64;
  parameter int HALVES = 2;
  localparam int DATA_W = HALF_W * HALVES;
  localparam int SYN_W = $clog2(HALF_W + $clog2(HALF_W) + 1);
  localparam int CHK_W = SYN_W + 1;
  localparam int WORD_W = (HALF_W + CHK_W) * HALVES;
  localparam int LAST_POS = HALF_W + SYN_W;

  typedef struct packed {
    logic [HALVES-1:0] corr;
    logic [HALVES-1:0] uncorr;
  } eccStrobe_t;

  // Hamming position of data bit idx: the idx-th non-power-of-two from 3 up
  function automatic int dataPos(input int idx);
    int n;
    int res;
    n = 0;
    res = 0;
    for (int p = 3; p < (1 << SYN_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) res = p;
        n++;
      end
    end
    return res;
  endfunction

  function automatic logic [CHK_W-1:0] checkByte(input logic [HALF_W-1:0] d);
    logic [SYN_W-1:0] c;
    int pos;
    c = '0;
    for (int i = 0; i < HALF_W; i++) begin
      pos = dataPos(i);
      for (int k = 0; k < SYN_W; k++)
        if (pos[k]) c[k] = c[k] ^ d[i];
    end
    return {(^d) ^ (^c), c};
  endfunction
endpackage

// File: rtl/pairEccDatapath.sv
module pairEccDatapath
  import pairEccPkg::*;
(
  input  logic [DATA_W-1:0] wrData,
  input  logic [WORD_W-1:0] wrInject,
  output logic [WORD_W-1:0] wrWord,
  input  logic [WORD_W-1:0] rdWord,
  output logic [DATA_W-1:0] rdData,
  output eccStrobe_t        strobe
);
  logic [WORD_W-1:0] encWord;
  logic [HALVES-1:0] corrVec;
  logic [HALVES-1:0] uncVec;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HALF_W-1:0] inData;
    logic [HALF_W-1:0] rxData;
    logic [HALF_W-1:0] flip;
    logic [CHK_W-1:0]  genChk;
    logic [CHK_W-1:0]  rxChk;
    logic [CHK_W-1:0]  rxCalc;
    logic [SYN_W-1:0]  syn;
    logic              oddPar;
    logic              posOk;

    assign inData = wrData[h*HALF_W +: HALF_W];
    assign genChk = checkByte(inData);

    // pairwise interleave: half h occupies every HALVES-th bit
    for (genvar i = 0; i < HALF_W; i++) begin : g_dbit
      assign encWord[HALVES*i + h] = inData[i];
      assign rxData[i] = rdWord[HALVES*i + h];
      assign flip[i] = oddPar && posOk && (syn == SYN_W'(dataPos(i)));
    end
    for (genvar j = 0; j < CHK_W; j++) begin : g_cbit
      assign encWord[DATA_W + HALVES*j + h] = genChk[j];
      assign rxChk[j] = rdWord[DATA_W + HALVES*j + h];
    end

    assign rxCalc = checkByte(rxData);
    assign syn    = rxCalc[SYN_W-1:0] ^ rxChk[SYN_W-1:0];
    assign oddPar = (^rxData) ^ (^rxChk);
    assign posOk  = (int'(syn) <= LAST_POS);

    assign rdData[h*HALF_W +: HALF_W] = rxData ^ flip;
    assign corrVec[h] = oddPar && posOk;
    assign uncVec[h]  = (!oddPar && (syn != '0)) || (oddPar && !posOk);
  end

  assign wrWord = encWord ^ wrInject;
  assign strobe = '{corr: corrVec, uncorr: uncVec};
endmodule

// File: rtl/pairEccControl.sv
module pairEccControl
  import pairEccPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  eccStrobe_t        strobe,
  output logic              stValid,
  output logic [HALVES-1:0] stCorr,
  output logic [HALVES-1:0] stUncorr,
  output logic              evCorr,
  output logic              evUncorr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stValid  <= 1'b0;
      stCorr   <= '0;
      stUncorr <= '0;
      evCorr   <= 1'b0;
      evUncorr <= 1'b0;
    end else begin
      stValid  <= rdValid;
      evCorr   <= rdValid && (|strobe.corr);
      evUncorr <= rdValid && (|strobe.uncorr);
      if (rdValid) begin
        stCorr   <= strobe.corr;
        stUncorr <= strobe.uncorr;
      end
    end
  end
endmodule

// File: rtl/pairEccGuard.sv
module pairEccGuard
  import pairEccPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic [WORD_W-1:0] wrInject,
  output logic [WORD_W-1:0] wrWord,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] rdWord,
  output logic [DATA_W-1:0] rdData,
  output logic              stValid,
  output logic [HALVES-1:0] stCorr,
  output logic [HALVES-1:0] stUncorr,
  output logic              evCorr,
  output logic              evUncorr
);
  eccStrobe_t strobe;

  pairEccDatapath u_dp (
    .wrData  (wrData),
    .wrInject(wrInject),
    .wrWord  (wrWord),
    .rdWord  (rdWord),
    .rdData  (rdData),
    .strobe  (strobe)
  );

  pairEccControl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .rdValid (rdValid),
    .strobe  (strobe),
    .stValid (stValid),
    .stCorr  (stCorr),
    .stUncorr(stUncorr),
    .evCorr  (evCorr),
    .evUncorr(evUncorr)
  );
endmodule

// File: rtl/pairEccChecker.sv
module pairEccChecker
  import pairEccPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] wrInject,
  input logic [WORD_W-1:0] wrWord,
  input logic              rdValid,
  input logic [WORD_W-1:0] rdWord,
  input logic              stValid,
  input logic [HALVES-1:0] stCorr,
  input logic [HALVES-1:0] stUncorr,
  input logic              evCorr,
  input logic              evUncorr
);
  // R8
  strobe_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> stValid);
  // R8
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !stValid);
  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> ($stable(stCorr) && $stable(stUncorr)));
  // R6
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stCorr & stUncorr) == '0);
  // R10
  ev_corr_chk: assert property (@(posedge clk) disable iff (!rstN)
    evCorr |-> (stValid && (|stCorr)));
  // R10
  ev_uncorr_chk: assert property (@(posedge clk) disable iff (!rstN)
    evUncorr |-> (stValid && (|stUncorr)));
  // R4
  clean_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && (rdWord == wrWord) && (wrInject == '0)) |=> ((stCorr == '0) && (stUncorr == '0)));
endmodule

bind pairEccGuard pairEccChecker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrInject(wrInject),
  .wrWord  (wrWord),
  .rdValid (rdValid),
  .rdWord  (rdWord),
  .stValid (stValid),
  .stCorr  (stCorr),
  .stUncorr(stUncorr),
  .evCorr  (evCorr),
  .evUncorr(evUncorr)
);

// File: tb/pairEccGuard_test.sv
`timescale 1ns/1ps
module pairEccGuard_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [127:0] wrData = '0;
  logic [143:0] wrInject = '0;
  logic [143:0] wrWord;
  logic rdValid = 1'b0;
  logic [143:0] rdWord = '0;
  logic [127:0] rdData;
  logic stValid;
  logic [1:0] stCorr, stUncorr;
  logic evCorr, evUncorr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic expValid = 0;
  logic [1:0] expCorr = '0, expUnc = '0;
  logic expEvC = 0, expEvU = 0;

  always #5 clk = ~clk;

  pairEccGuard uut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrInject(wrInject), .wrWord(wrWord),
    .rdValid(rdValid), .rdWord(rdWord), .rdData(rdData), .stValid(stValid),
    .stCorr(stCorr), .stUncorr(stUncorr), .evCorr(evCorr), .evUncorr(evUncorr)
  );

  task automatic check(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model: builds each half's 72-bit codeword by position
  function automatic logic [143:0] modelEnc(input logic [127:0] d);
    logic [143:0] w;
    logic [71:0] cw;
    int n;
    logic par;
    w = '0;
    for (int h = 0; h < 2; h++) begin
      cw = '0;
      n = 0;
      for (int p = 1; p < 72; p++)
        if ((p & (p - 1)) != 0) begin cw[p] = d[64*h + n]; n++; end
      for (int k = 0; k < 7; k++) begin
        par = 0;
        for (int p = 1; p < 72; p++) if (p[k]) par ^= cw[p];
        cw[1 << k] = par;
      end
      for (int i = 0; i < 64; i++) w[2*i + h] = d[64*h + i];
      for (int k = 0; k < 7; k++) w[128 + 2*k + h] = cw[1 << k];
      w[128 + 14 + h] = ^cw[71:1];
    end
    return w;
  endfunction

  function automatic int physOf(input int h, input int j);
    return (j < 64) ? (2*j + h) : (128 + 2*(j - 64) + h);
  endfunction

  // One clock step: check last cycle's registered results, then drive a new cycle
  task automatic step(input logic v, input logic [127:0] d, input logic [143:0] inj, input string req);
    logic [143:0] stored;
    logic [127:0] expData;
    int cnt;
    @(negedge clk);
    check(stValid == expValid, "R8 strobe", 144'(stValid), 144'(expValid));
    check(stCorr == expCorr, {req, " R5 corr flags"}, 144'(stCorr), 144'(expCorr));
    check(stUncorr == expUnc, {req, " R6 uncorr flags"}, 144'(stUncorr), 144'(expUnc));
    check(evCorr == expEvC, "R10 corr event", 144'(evCorr), 144'(expEvC));
    check(evUncorr == expEvU, "R10 uncorr event", 144'(evUncorr), 144'(expEvU));
    wrData = d;
    wrInject = inj;
    stored = modelEnc(d) ^ inj;
    rdWord = stored;
    rdValid = v;
    #1;
    check(wrWord == stored, "R1 R2 R3 stored word", wrWord, stored);
    expData = d;
    expEvC = 0; expEvU = 0;
    for (int h = 0; h < 2; h++) begin
      cnt = 0;
      for (int j = 0; j < 72; j++) if (inj[physOf(h, j)]) cnt++;
      if (cnt >= 2)
        for (int i = 0; i < 64; i++) expData[64*h + i] = stored[2*i + h];
      if (v) begin
        expCorr[h] = (cnt == 1);
        expUnc[h] = (cnt == 2);
      end
    end
    if (v) begin
      expEvC = |expCorr;
      expEvU = |expUnc;
    end
    expValid = v;
    if (v) check(rdData == expData, {req, " read data"}, 144'(rdData), 144'(expData));
  endtask

  initial begin
    logic [127:0] pat;
    logic [143:0] m;
    #1;
    check(stValid == 0 && stCorr == 0 && stUncorr == 0 && evCorr == 0 && evUncorr == 0,
          "R11 reset state", 144'({stValid, stCorr, stUncorr, evCorr, evUncorr}), 144'(0));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, '0, '0, "R11 idle");
    // R4 clean reads over several patterns
    step(1, '0, '0, "R4");
    step(1, '1, '0, "R4");
    step(1, {64{2'b10}}, '0, "R4");
    step(1, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, '0, "R4");
    pat = 128'h9e37_79b9_7f4a_7c15_f39c_c060_5d3b_2a81;
    // R5 every single-bit position in both halves
    for (int b = 0; b < 144; b++) begin
      m = '0; m[b] = 1'b1;
      step(1, pat, m, "R5 single");
      pat = {pat[126:0], pat[127] ^ pat[98]};
    end
    // R9 flags hold while no read
    m = '0; m[143] = 1'b1;
    step(1, pat, m, "R5 overall parity");
    step(0, '0, '0, "R9 hold");
    step(0, '1, '0, "R9 hold");
    // R6 double faults within one half
    for (int h = 0; h < 2; h++)
      for (int a = 0; a < 72; a += 5) begin
        int b2;
        b2 = (a * 7 + 3) % 72;
        if (b2 == a) b2 = (a + 1) % 72;
        m = '0; m[physOf(h, a)] = 1'b1; m[physOf(h, b2)] = 1'b1;
        step(1, pat, m, "R6 double");
        pat = ~{pat[0], pat[127:1]};
      end
    m = '0; m[128] = 1; m[130] = 1;
    step(1, pat, m, "R6 two check bits");
    // R7 adjacent physical bit bursts
    for (int k = 0; k < 72; k += 7) begin
      m = '0; m[2*k] = 1'b1; m[2*k + 1] = 1'b1;
      step(1, pat, m, "R7 adjacent");
    end
    // R6 and R5 together on separate halves, then mixed flags
    m = '0; m[0] = 1; m[2] = 1; m[3] = 1;
    step(1, pat, m, "R6 R5 mixed");
    step(1, pat, '0, "R4 after error");
    step(0, '0, '0, "R10 quiet");
    step(0, '0, '0, "R10 quiet");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule